// File: doc/BRIEF.md
# Link Bring-Up Sequencer

This block steps a serial radio-link interface through its start-up phases: idle standby, layer-1 synchronisation, protocol setup, control-and-management (C&M) setup, interface and vendor-specific negotiation, and normal operation. A passive-link state hangs off operation. Four negotiation-done flags gate the forward steps. A single 32-bit status/control word reports the current phase code and holds those four flags.

Software sets the flags through a one-cycle register write port. When hardware sequencing is enabled, four dedicated pins drive the flags directly instead, and software writes to the flags are dropped. Two auto-completion controls let the block raise the protocol flag and the C&M flag by itself. When a link loses layer-1 synchronisation at protocol setup or any later phase, the block falls back to the synchronisation phase and discards the flags that phase does not keep.

Top module: `link_bringup_seq`

## Requirements
- R1: `reg_rdata[10:8]` carries the phase code. The codes are standby 000, L1 sync 001, protocol setup 011, C&M setup 010, interface negotiation 110, operation 111 and passive 101. The code 100 never appears.
- R2: After reset, `reg_rdata` reads all zero: the phase is standby and all flags are clear.
- R3: Standby moves to L1 sync one cycle after `link_en` is 1. L1 sync moves to protocol setup only when `l1_sync_ok` is 1 and flag bit 0 (bit-rate done) is 1.
- R4: Protocol setup advances to C&M setup only when bit 1 (protocol done) is 1. C&M setup advances to interface negotiation only when bit 2 (C&M done) is 1. Interface negotiation advances to operation only when bit 3 (vendor-specific done) is 1. Each step happens on the clock edge after the flag reads as 1.
- R5: With `hw_seq_en` at 0, a write with `reg_wr` loads flag bits 3:0 from `reg_wdata[3:0]` on the next edge. All other written bits have no effect. Bits 7:4 and 31:11 always read zero. The phase field cannot be written.
- R6: With `hw_seq_en` at 1, each flag takes the value of `done_pins` at the same bit position on every edge, and register writes to the flags are ignored.
- R7: When `prot_auto` is 1 during protocol setup, bit 1 becomes 1 on the next edge.
- R8: When `cm_slow_auto` or `cm_fast_auto` is 1 during C&M setup, bit 2 becomes 1 on the next edge.
- R9: If `l1_sync_ok` is 0 in protocol setup or any later phase, the next edge returns the phase to L1 sync and clears bits 3:1, while bit 0 is kept. This clear takes priority over writes, pins and auto-completion.
- R10: In operation, `passive_mode` at 1 moves the phase to passive on the next edge. In passive, `passive_mode` at 0 returns the phase to operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Starts bring-up from standby |
| l1_sync_ok | input | 1 | Layer-1 synchronisation achieved |
| passive_mode | input | 1 | Requests the passive-link state from operation |
| hw_seq_en | input | 1 | Flags are driven by pins instead of register writes |
| done_pins | input | 4 | Negotiation-done pins; the bit index matches the flag index |
| prot_auto | input | 1 | Auto-completes the protocol flag |
| cm_slow_auto | input | 1 | Auto-completes the C&M flag (slow channel) |
| cm_fast_auto | input | 1 | Auto-completes the C&M flag (fast channel) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Status/control word |

## Verification
The bench holds each gating flag at 0 and checks that the phase does not move. A design that advanced early would skip a negotiation phase. It drives loss of synchronisation together with a software write of all ones. A design that let the write win would keep stale flags and jump straight back into later phases. In hardware mode it writes ones while the pins are low, which catches a design that still accepts software writes. It also leaves bit 0 set across a fallback, so a design that clears every flag would stall in L1 sync.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  localparam int NFLAG     = 4;
  localparam int STW       = 3;
  localparam int FLAG_RATE = 0;
  localparam int FLAG_PROT = 1;
  localparam int FLAG_CM   = 2;
  localparam int FLAG_VSS  = 3;

  // Adjacent phases differ in one bit; code 3'b100 is unused.
  typedef enum logic [STW-1:0] {
    ST_STBY = 3'b000,
    ST_L1   = 3'b001,
    ST_PROT = 3'b011,
    ST_CM   = 3'b010,
    ST_IFN  = 3'b110,
    ST_OPER = 3'b111,
    ST_PASV = 3'b101
  } lbs_state_e;
endpackage

// File: rtl/lbs_fsm.sv
module lbs_fsm
  import lbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             link_en,
  input  logic             l1_sync_ok,
  input  logic             passive_mode,
  input  logic [NFLAG-1:0] flags,
  output lbs_state_e       state,
  output logic             sync_clr,
  output logic             in_prot,
  output logic             in_cm
);
  lbs_state_e state_q, state_d;
  logic       synced_phase;

  // Phases past L1 sync that depend on keeping synchronisation.
  always_comb begin
    synced_phase = (state_q == ST_PROT) || (state_q == ST_CM) ||
                   (state_q == ST_IFN)  || (state_q == ST_OPER) ||
                   (state_q == ST_PASV);
  end

  assign sync_clr = synced_phase && !l1_sync_ok;
  assign in_prot  = (state_q == ST_PROT);
  assign in_cm    = (state_q == ST_CM);
  assign state    = state_q;

  always_comb begin
    state_d = state_q;
    if (sync_clr) begin
      state_d = ST_L1;
    end else begin
      unique case (state_q)
        ST_STBY: if (link_en)                           state_d = ST_L1;
        ST_L1:   if (l1_sync_ok && flags[FLAG_RATE])    state_d = ST_PROT;
        ST_PROT: if (flags[FLAG_PROT])                  state_d = ST_CM;
        ST_CM:   if (flags[FLAG_CM])                    state_d = ST_IFN;
        ST_IFN:  if (flags[FLAG_VSS])                   state_d = ST_OPER;
        ST_OPER: if (passive_mode)                      state_d = ST_PASV;
        ST_PASV: if (!passive_mode)                     state_d = ST_OPER;
        default:                                        state_d = ST_STBY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STBY;
    else        state_q <= state_d;
  end

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != lbs_state_e'(3'b100));
  p_l1_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_L1 && !(l1_sync_ok && flags[FLAG_RATE])) |=> state_q == ST_L1);
  p_prot_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PROT && !flags[FLAG_PROT]) |=> state_q != ST_CM);
  p_cm_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CM && !flags[FLAG_CM]) |=> state_q != ST_IFN);
  p_vss_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IFN && !flags[FLAG_VSS]) |=> state_q != ST_OPER);
  p_sync_fallback_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> state_q == ST_L1);
  p_passive_enter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPER && l1_sync_ok && passive_mode) |=> state_q == ST_PASV);
  p_passive_leave_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PASV && l1_sync_ok && !passive_mode) |=> state_q == ST_OPER);
endmodule

// File: rtl/lbs_flag_bank.sv
module lbs_flag_bank #(
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_en,
  input  logic          wr_en,
  input  logic [NF-1:0] wr_flags,
  input  logic [NF-1:0] pin_flags,
  input  logic [NF-1:0] auto_set,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    logic flag_q, flag_d, flag_en;

    // Priority: sync-loss clear, auto-completion, pin/software source.
    always_comb begin
      flag_en = 1'b0;
      flag_d  = flag_q;
      if (clr_mask[i]) begin
        flag_en = 1'b1;
        flag_d  = 1'b0;
      end else if (auto_set[i]) begin
        flag_en = 1'b1;
        flag_d  = 1'b1;
      end else if (hw_en) begin
        flag_en = 1'b1;
        flag_d  = pin_flags[i];
      end else if (wr_en) begin
        flag_en = 1'b1;
        flag_d  = wr_flags[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (flag_en) flag_q <= flag_d;
    end

    assign flags[i] = flag_q;

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_mask[i] |=> !flags[i]);
    p_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_set[i] && !clr_mask[i]) |=> flags[i]);
    p_pin_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_en && !clr_mask[i] && !auto_set[i]) |=> flags[i] == $past(pin_flags[i]));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hw_en && !wr_en && !clr_mask[i] && !auto_set[i]) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/lbs_regmap.sv
module lbs_regmap
  import lbs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STATE_LSB = 8
) (
  input  lbs_state_e       state,
  input  logic [NFLAG-1:0] flags,
  input  logic [DATA_W-1:0] wdata,
  output logic [NFLAG-1:0] wr_flags,
  output logic [DATA_W-1:0] rdata
);
  localparam int STATE_MSB = STATE_LSB + STW - 1;

  logic wdata_hi_unused;

  always_comb begin
    rdata = '0;
    rdata[NFLAG-1:0]          = flags;
    rdata[STATE_MSB:STATE_LSB] = state;
  end

  assign wr_flags        = wdata[NFLAG-1:0];
  assign wdata_hi_unused = ^wdata[DATA_W-1:NFLAG];
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
  import lbs_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STATE_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              l1_sync_ok,
  input  logic              passive_mode,
  input  logic              hw_seq_en,
  input  logic [NFLAG-1:0]  done_pins,
  input  logic              prot_auto,
  input  logic              cm_slow_auto,
  input  logic              cm_fast_auto,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  lbs_state_e       state;
  logic [NFLAG-1:0] flags, wr_flags, auto_set, clr_mask;
  logic             sync_clr, in_prot, in_cm;

  // Bit-rate flag survives a sync fallback; the later ones do not.
  always_comb begin
    clr_mask            = {NFLAG{sync_clr}};
    clr_mask[FLAG_RATE] = 1'b0;
    auto_set            = '0;
    auto_set[FLAG_PROT] = prot_auto & in_prot;
    auto_set[FLAG_CM]   = (cm_slow_auto | cm_fast_auto) & in_cm;
  end

  lbs_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_en      (link_en),
    .l1_sync_ok   (l1_sync_ok),
    .passive_mode (passive_mode),
    .flags        (flags),
    .state        (state),
    .sync_clr     (sync_clr),
    .in_prot      (in_prot),
    .in_cm        (in_cm)
  );

  lbs_flag_bank #(.NF(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_en     (hw_seq_en),
    .wr_en     (reg_wr),
    .wr_flags  (wr_flags),
    .pin_flags (done_pins),
    .auto_set  (auto_set),
    .clr_mask  (clr_mask),
    .flags     (flags)
  );

  lbs_regmap #(.DATA_W(DATA_W), .STATE_LSB(STATE_LSB)) u_regmap (
    .state    (state),
    .flags    (flags),
    .wdata    (reg_wdata),
    .wr_flags (wr_flags),
    .rdata    (reg_rdata)
  );

  p_sw_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_seq_en && reg_wr && !sync_clr && auto_set == '0)
      |=> reg_rdata[NFLAG-1:0] == $past(done_pins));
  p_bitrate_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_clr && !hw_seq_en && !reg_wr) |=> $stable(reg_rdata[FLAG_RATE]));
endmodule

// File: tb/link_bringup_seq_bench.sv
module link_bringup_seq_bench;
  localparam logic [2:0] S_STBY = 3'b000, S_L1 = 3'b001, S_PROT = 3'b011,
                         S_CM = 3'b010, S_IFN = 3'b110, S_OPER = 3'b111,
                         S_PASV = 3'b101;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_en, l1_sync_ok, passive_mode, hw_seq_en;
  logic [3:0]  done_pins;
  logic        prot_auto, cm_slow_auto, cm_fast_auto, reg_wr;
  logic [31:0] reg_wdata, reg_rdata;

  int n_total = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit finished = 0;

  logic [31:0] q_exp[$];
  string       q_tag[$];
  int          q_due[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_bringup_seq u_link_bringup_seq (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .l1_sync_ok(l1_sync_ok),
    .passive_mode(passive_mode), .hw_seq_en(hw_seq_en), .done_pins(done_pins),
    .prot_auto(prot_auto), .cm_slow_auto(cm_slow_auto), .cm_fast_auto(cm_fast_auto),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] word(input logic [2:0] st, input logic [3:0] fl);
    word = {21'b0, st, 4'b0, fl};
  endfunction

  // Driver: expected word is due after the next rising edge.
  task automatic tick(input logic [31:0] e, input string t);
    q_exp.push_back(e);
    q_tag.push_back(t);
    q_due.push_back(cyc + 1);
    @(negedge clk);
  endtask

  // Monitor: compares each item once its edge has passed.
  always @(negedge clk) begin
    while (q_due.size() > 0 && q_due[0] <= cyc) begin
      logic [31:0] e;
      string       t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      void'(q_due.pop_front());
      n_total++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; link_en = 0; l1_sync_ok = 0; passive_mode = 0; hw_seq_en = 0;
    done_pins = 4'h0; prot_auto = 0; cm_slow_auto = 0; cm_fast_auto = 0;
    reg_wr = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(word(S_STBY, 4'h0), "R2 reset word");
    // R5: only bits 3:0 land; state and reserved bits stay as computed
    reg_wr = 1; reg_wdata = 32'hFFFF_FFF1;
    tick(word(S_STBY, 4'h1), "R5 write with junk bits");
    reg_wr = 0; reg_wdata = '0;
    tick(word(S_STBY, 4'h1), "R5 hold without write");
    link_en = 1;
    tick(word(S_L1, 4'h1), "R3 standby to L1");
    tick(word(S_L1, 4'h1), "R3 L1 waits for sync");
    l1_sync_ok = 1;
    tick(word(S_PROT, 4'h1), "R1 protocol code 011");
    tick(word(S_PROT, 4'h1), "R4 protocol flag missing");
    reg_wr = 1; reg_wdata = 32'h0000_0003;
    tick(word(S_PROT, 4'h3), "R5 set protocol flag");
    reg_wr = 0;
    tick(word(S_CM, 4'h3), "R4 protocol to C&M");
    cm_fast_auto = 1;
    tick(word(S_CM, 4'h7), "R8 fast auto sets C&M flag");
    cm_fast_auto = 0;
    tick(word(S_IFN, 4'h7), "R4 C&M to interface");
    tick(word(S_IFN, 4'h7), "R4 vendor flag missing");
    reg_wr = 1; reg_wdata = 32'h0000_000F;
    tick(word(S_IFN, 4'hF), "R5 set vendor flag");
    reg_wr = 0;
    tick(word(S_OPER, 4'hF), "R4 interface to operation");
    passive_mode = 1;
    tick(word(S_PASV, 4'hF), "R10 enter passive");
    tick(word(S_PASV, 4'hF), "R10 stay passive");
    passive_mode = 0;
    tick(word(S_OPER, 4'hF), "R10 leave passive");
    // R9: sync loss beats a simultaneous write of ones
    l1_sync_ok = 0; reg_wr = 1; reg_wdata = 32'h0000_000F;
    tick(word(S_L1, 4'h1), "R9 fallback clears 3:1");
    reg_wr = 0;
    tick(word(S_L1, 4'h1), "R9 stay in L1 unsynced");
    l1_sync_ok = 1;
    tick(word(S_PROT, 4'h1), "R3 resync with kept bit 0");
    prot_auto = 1;
    tick(word(S_PROT, 4'h3), "R7 auto sets protocol flag");
    prot_auto = 0;
    tick(word(S_CM, 4'h3), "R7 auto flag advances");
    cm_slow_auto = 1;
    tick(word(S_CM, 4'h7), "R8 slow auto sets C&M flag");
    cm_slow_auto = 0;
    tick(word(S_IFN, 4'h7), "R8 slow auto flag advances");
    // R6: pins drive flags; writes ignored
    hw_seq_en = 1; done_pins = 4'b0101; reg_wr = 1; reg_wdata = 32'h0000_000F;
    tick(word(S_IFN, 4'h5), "R6 pins override write");
    reg_wr = 0;
    tick(word(S_IFN, 4'h5), "R6 vendor pin low");
    done_pins = 4'b1101;
    tick(word(S_IFN, 4'hD), "R6 vendor pin high");
    tick(word(S_OPER, 4'hD), "R6 pin flag advances");
    l1_sync_ok = 0;
    tick(word(S_L1, 4'h1), "R9 clear beats pins");
    tick(word(S_L1, 4'hD), "R6 pins copied again");
    hw_seq_en = 0; done_pins = 4'h0;
    tick(word(S_L1, 4'hD), "R6 hold after leaving hw mode");
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule